// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous memory with registered inputs and a registered read output. Each word holds four byte lanes of nine bits each (eight data bits plus one parity bit). An access begins when one of two address strobes is low at a rising clock edge. The processor-side strobe always begins a read. The controller-side strobe begins a read or a write, depending on the write inputs. After an access has begun, the cycles that follow without a strobe can walk through a four-beat burst. The burst follows either a linear or an interleaved order within an aligned group of four words. The advance input can hold the burst on the current word.

Writes complete at the edge where they are presented, and byte lanes can be masked. The shared data bus is modelled as separate input, output and output-enable signals. The output enable is combinational in the output-enable input and in the presence of a write. An asynchronous sleep request stops all accesses after two clock edges. Sleep keeps the array contents, and the memory resumes two edges after the request is released. The default depth is kept small so that it elaborates quickly. Setting `ADDR_W` to 15 gives 32K words of 36 bits.

Top module: `burst_sram`

## Requirements
- R1: The block is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 at the strobe edge. A strobe with any other combination writes nothing and produces no read data. The cycles without a strobe that follow it also write nothing.
- R2: A write occurs at the edge when `strobe_ctl_n`=0, `strobe_cpu_n`=1, the block is selected and a write is requested. The write goes to `addr`, and `adv_n` has no effect in that cycle.
- R3: Lane i is `dq` bits [9i+8:9i]. `wr_all_n`=0 writes all four lanes. Otherwise, `wr_byte_n`=0 writes each lane whose `lane_wr_n[i]`=0. Lanes that are not written keep their contents. With `wr_all_n`=1 and `wr_byte_n`=1 the cycle is a read.
- R4: At beat k (0 to 3) of a burst, the two low address bits are (base+k) mod 4 when `lin_mode`=1 and base XOR k when `lin_mode`=0. The upper address bits keep the value captured at the strobe. The beat index advances only in a cycle with no strobe and `adv_n`=0, and it wraps after beat 3.
- R5: When both strobes are low, the processor-side strobe wins and the cycle is a read, whatever the write inputs are. A cycle with no strobe that immediately follows it and requests a write stores the data at the captured address.
- R6: `dq_oe` is 1 only when read data is valid, `oe_n`=0, no write is being performed in the current cycle and the block is awake. It follows `oe_n` and the write inputs without waiting for a clock edge.
- R7: A read presented at edge k shows its word on `dq_out` with `dq_oe`=1 after edge k+1. Each later burst beat appears one edge after the beat before it.
- R8: A cycle with no strobe and `adv_n`=1 after a read start reads the same word again.
- R9: Accesses presented at the first two edges after `sleep_req` rises still complete, and accesses at later edges are ignored. Accesses at the first two edges after it falls are also ignored. The contents are unchanged across sleep, and `dq_oe` is 0 while asleep.
- R10: After reset, `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, captured on a strobe |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low, read only |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| sel1_n | input | 1 | Select, active low |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Per-lane write enable, active low |
| lane_wr_n | input | LANES | Lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| dq_in | input | LANES*LANE_W | Write data |
| lin_mode | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| sleep_req | input | 1 | Asynchronous sleep request |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A read presented at edge k is due after edge k+1, and each burst beat is due one edge after the previous beat. The driver records, for each read it issues, the edge number at which the word is due and the word itself, taken from its own model of the array. The monitor samples a few nanoseconds after each edge and compares only the entry whose due edge has arrived. It flags any entry whose due edge has passed without a match. Effects that need no clock edge (`oe_n` and write-driven tristate) are checked between edges, just after the inputs change. Writes that should be ignored, and the two-edge sleep windows, are checked by reading the affected words back later.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // low address bits for beat k of a burst starting at base
  function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                         input logic [1:0] k,
                                         input logic       lin);
    return lin ? (base + k) : (base ^ k);
  endfunction

endpackage

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
  import burst_sram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] load_lo,
  input  logic       step,
  input  logic       lin,
  output logic [1:0] cur_lo,
  output logic [1:0] nxt_lo
);

  logic [1:0] base_q, base_d;
  logic [1:0] cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = load_lo;
      cnt_d  = 2'd0;
    end else if (step) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= 2'd0;
      cnt_q  <= 2'd0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_lo = beat_lo(base_q, cnt_q, lin);
  assign nxt_lo = beat_lo(base_q, cnt_q + 2'd1, lin);

  assert_seq_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_lo == $past(load_lo)));

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ((cur_lo == $past(nxt_lo)) || (lin != $past(lin))));

endmodule

// File: rtl/burst_sram_doze.sv
module burst_sram_doze (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic doze
);

  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= req;
      s2_q <= s1_q;
    end
  end

  assign doze = s2_q;

  assert_doze_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doze) |-> ($past(req) && $past(req, 2)));

  assert_doze_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doze) |-> (!$past(req) && !$past(req, 2)));

endmodule

// File: rtl/burst_sram_lane.sv
module burst_sram_lane #(
  parameter int ADDR_W = 10,
  parameter int W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (re) rdata <= arr[raddr];
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  input  logic                    lin_mode,
  input  logic                    sleep_req,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int HI_W = ADDR_W - 2;

  logic              doze, awake;
  logic              sel_in, start_p, start_c, start, cont, step;
  logic [LANES-1:0]  lane_mask, lane_we;
  logic              wr_req, wr_go, rd_go;
  logic [1:0]        cur_lo, nxt_lo;
  logic [ADDR_W-1:0] tgt;

  logic [HI_W-1:0]   hi_q, hi_d;
  logic              act_q, act_d;
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic              vld_q, vld_d;

  burst_sram_doze u_doze (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (sleep_req),
    .doze (doze)
  );

  burst_sram_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .load_lo(addr[1:0]),
    .step   (step),
    .lin    (lin_mode),
    .cur_lo (cur_lo),
    .nxt_lo (nxt_lo)
  );

  // cycle decode
  always_comb begin
    awake   = !doze;
    sel_in  = !sel1_n && sel2 && !sel3_n;
    start_p = awake && !strobe_cpu_n;
    start_c = awake && strobe_cpu_n && !strobe_ctl_n;
    start   = start_p || start_c;
    cont    = awake && strobe_cpu_n && strobe_ctl_n && act_q;
    step    = cont && !adv_n;

    if (!wr_all_n)       lane_mask = '1;
    else if (!wr_byte_n) lane_mask = ~lane_wr_n;
    else                 lane_mask = '0;
    wr_req = (lane_mask != '0);

    tgt   = start ? addr : {hi_q, (step ? nxt_lo : cur_lo)};
    wr_go = (start_c && sel_in && wr_req) || (cont && wr_req);
    rd_go = (start_p && sel_in) || (start_c && sel_in && !wr_req) ||
            (cont && !wr_req);
    lane_we = {LANES{wr_go}} & lane_mask;
  end

  // next state
  always_comb begin
    hi_d    = start ? addr[ADDR_W-1:2] : hi_q;
    if (start)     act_d = sel_in;
    else if (doze) act_d = 1'b0;
    else           act_d = act_q;
    rd_d    = rd_go;
    raddr_d = tgt;
    vld_d   = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      raddr_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      hi_q    <= hi_d;
      act_q   <= act_d;
      rd_q    <= rd_d;
      raddr_q <= raddr_d;
      vld_q   <= vld_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    burst_sram_lane #(.ADDR_W(ADDR_W), .W(LANE_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (lane_we[g]),
      .waddr(tgt),
      .wdata(dq_in[g*LANE_W +: LANE_W]),
      .re   (rd_q),
      .raddr(raddr_q),
      .rdata(dq_out[g*LANE_W +: LANE_W])
    );
  end

  assign dq_oe = vld_q && !oe_n && !wr_go && awake;

  assert_read_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> ##1 vld_q);

  assert_wr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> !dq_oe);

  assert_doze_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    doze |-> (lane_we == '0));

  assert_desel_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sel_in) |=> (!rd_q && !act_q));

endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;

  localparam int AW = 10;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          strobe_cpu_n, strobe_ctl_n, sel1_n, sel2, sel3_n, adv_n;
  logic          wr_all_n, wr_byte_n, oe_n, lin_mode, sleep_req;
  logic [3:0]    lane_wr_n;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  burst_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
    .oe_n(oe_n), .dq_in(dq_in), .lin_mode(lin_mode), .sleep_req(sleep_req),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #10 clk = ~clk;   // 50 MHz

  int total = 0;
  int bad   = 0;
  int edges = 0;
  bit done  = 1'b0;

  logic [DW-1:0] model [1 << AW];
  int            due_q [$];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always @(posedge clk) edges++;

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #5;
    while (due_q.size() > 0 && due_q[0] < edges) begin
      total++; bad++;
      $display("FAIL %s: got no data expected %h", tag_q[0], exp_q[0]);
      void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
    if (due_q.size() > 0 && due_q[0] == edges) begin
      chk(tag_q[0], {dq_oe, dq_out}, {1'b1, exp_q[0]});
      void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_idle();
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1;
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
    adv_n = 1'b1; wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_wr_n = 4'hF;
    oe_n = 1'b0; dq_in = '0; addr = '0;
  endtask

  task automatic expect_rd(input logic [DW-1:0] d, input string tag);
    due_q.push_back(edges + 2);
    exp_q.push_back(d);
    tag_q.push_back(tag);
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] d,
                                          input logic [3:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = d[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a,
                                              input int k, input logic lin);
    logic [1:0] lo = lin ? a[1:0] + 2'(k) : a[1:0] ^ 2'(k);
    return {a[AW-1:2], lo};
  endfunction

  // controller-strobe write; adv_n held low to show it is ignored (R2)
  task automatic wr_ctl(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [3:0] m);
    set_idle();
    strobe_ctl_n = 1'b0; addr = a; dq_in = d; adv_n = 1'b0;
    if (m == 4'hF) wr_all_n = 1'b0;
    else begin wr_byte_n = 1'b0; lane_wr_n = ~m; end
    model[a] = merge(model[a], d, m);
    tick();
    set_idle();
  endtask

  task automatic rd_cpu(input logic [AW-1:0] a, input string tag);
    set_idle();
    strobe_cpu_n = 1'b0; addr = a;
    expect_rd(model[a], tag);
    tick();
    set_idle();
    tick();
  endtask

  task automatic burst_wr(input logic [AW-1:0] a, input logic [DW-1:0] seed);
    wr_ctl(a, seed, 4'hF);
    for (int k = 1; k < 4; k++) begin
      adv_n = 1'b0; wr_all_n = 1'b0; dq_in = seed + DW'(k);
      model[beat_addr(a, k, lin_mode)] = seed + DW'(k);
      tick();
    end
    set_idle();
    tick();
  endtask

  // hold[k-1]=1 keeps beat k on the previous word (R8)
  task automatic burst_rd(input logic [AW-1:0] a, input logic [2:0] hold,
                          input string tag);
    int idx = 0;
    set_idle();
    strobe_cpu_n = 1'b0; addr = a;
    expect_rd(model[a], tag);
    tick();
    set_idle();
    for (int k = 1; k < 4; k++) begin
      adv_n = hold[k-1];
      if (!hold[k-1]) idx++;
      expect_rd(model[beat_addr(a, idx, lin_mode)], tag);
      tick();
    end
    set_idle();
    tick();
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lin_mode = 1'b1; sleep_req = 1'b0;
    set_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R10", {35'd0, dq_oe}, '0);

    // R2 full-word write, then read back
    wr_ctl(10'd5, 36'h1_2345_6789, 4'hF);
    rd_cpu(10'd5, "R2");

    // R3 masked lanes 0 and 2
    wr_ctl(10'd5, 36'hA_BCDE_F012, 4'b0101);
    rd_cpu(10'd5, "R3");
    // R3 controller strobe without write inputs is a read
    set_idle(); strobe_ctl_n = 1'b0; addr = 10'd5;
    expect_rd(model[5], "R3");
    tick(); set_idle(); tick();

    // R2 adv_n ignored in the strobe cycle
    wr_ctl(10'd21, 36'h0_0000_0021, 4'hF);
    wr_ctl(10'd20, 36'h0_0000_0020, 4'hF);
    rd_cpu(10'd21, "R2");
    rd_cpu(10'd20, "R2");

    // R4 linear write from low bits 2, read back linear and interleaved
    lin_mode = 1'b1;
    burst_wr(10'd10, 36'h3_0000_0100);
    burst_rd(10'd10, 3'b000, "R4");
    lin_mode = 1'b0;
    burst_rd(10'd11, 3'b000, "R4");
    // R4 interleaved write from low bits 1, read back linearly
    burst_wr(10'd33, 36'h4_0000_0200);
    lin_mode = 1'b1;
    burst_rd(10'd32, 3'b000, "R4");

    // R8 suspended beat
    burst_rd(10'd32, 3'b010, "R8");

    // R5 both strobes low with write inputs: read only
    wr_ctl(10'd40, 36'h5_0000_0040, 4'hF);
    set_idle();
    strobe_cpu_n = 1'b0; strobe_ctl_n = 1'b0; addr = 10'd40;
    wr_all_n = 1'b0; dq_in = 36'hF_FFFF_FFFF;
    expect_rd(model[40], "R5");
    tick(); set_idle(); tick();
    rd_cpu(10'd40, "R5");
    // R5 write data taken in the cycle after the processor strobe
    wr_ctl(10'd41, 36'h5_0000_0041, 4'hF);
    set_idle(); strobe_cpu_n = 1'b0; addr = 10'd41;
    tick();
    set_idle(); wr_all_n = 1'b0; dq_in = 36'h5_5555_0F2F;
    model[41] = 36'h5_5555_0F2F;
    tick(); set_idle(); tick();
    rd_cpu(10'd41, "R5");

    // R1 each deselecting combination blocks writes
    for (int v = 0; v < 3; v++) begin
      set_idle();
      if (v == 0) sel1_n = 1'b1;
      if (v == 1) sel2 = 1'b0;
      if (v == 2) sel3_n = 1'b1;
      strobe_ctl_n = 1'b0; addr = 10'd5; wr_all_n = 1'b0; dq_in = 36'h0_DEAD_0001;
      tick();
      strobe_ctl_n = 1'b1; dq_in = 36'h0_DEAD_0002;
      tick();
      set_idle();
      rd_cpu(10'd5, "R1");
    end
    // R1 deselected read gives no output
    set_idle(); sel3_n = 1'b1; strobe_cpu_n = 1'b0; addr = 10'd5;
    tick(); set_idle(); tick();
    chk("R1", {35'd0, dq_oe}, '0);

    // R6 combinational output enable and write tristate; R7 timing
    set_idle(); strobe_cpu_n = 1'b0; addr = 10'd5;
    tick(); set_idle();
    chk("R7", {35'd0, dq_oe}, '0);
    tick();
    #1 chk("R7", {dq_oe, dq_out[34:0]}, {1'b1, model[5][34:0]});
    oe_n = 1'b1;
    #1 chk("R6", {35'd0, dq_oe}, '0);
    oe_n = 1'b0;
    #1 chk("R6", {35'd0, dq_oe}, 36'd1);
    wr_all_n = 1'b0; dq_in = model[5];
    #1 chk("R6", {35'd0, dq_oe}, '0);
    tick(); set_idle(); tick();

    // R9 sleep entry and exit windows
    wr_ctl(10'd50, 36'h9_0000_0050, 4'hF);
    wr_ctl(10'd51, 36'h9_0000_0051, 4'hF);
    wr_ctl(10'd52, 36'h9_0000_0052, 4'hF);
    set_idle(); sleep_req = 1'b1;
    tick();
    strobe_ctl_n = 1'b0; addr = 10'd50; wr_all_n = 1'b0; dq_in = 36'h9_1111_1111;
    model[50] = 36'h9_1111_1111;
    tick();
    dq_in = 36'h9_2222_2222;           // third edge: ignored
    tick();
    set_idle(); strobe_cpu_n = 1'b0; addr = 10'd50;
    tick();
    set_idle(); sleep_req = 1'b0;
    chk("R9", {35'd0, dq_oe}, '0);
    tick();
    chk("R9", {35'd0, dq_oe}, '0);
    strobe_ctl_n = 1'b0; addr = 10'd51; wr_all_n = 1'b0; dq_in = 36'h9_3333_3333;
    tick();
    addr = 10'd52; dq_in = 36'h9_4444_4444;
    model[52] = 36'h9_4444_4444;
    tick();
    set_idle(); tick();
    rd_cpu(10'd50, "R9");
    rd_cpu(10'd51, "R9");
    rd_cpu(10'd52, "R9");
    rd_cpu(10'd21, "R9");

    repeat (4) tick();
    if (due_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", due_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule